// File: doc/BRIEF.md
# Card-Side Reset Pulse Generator

This block drives the reset lines of a plug-in card. It provides two registered outputs that always carry opposite levels, one active high and one active low. The card is held in reset while any supply monitor flag reports a low rail, while the power-enable input is low, or while the power controller asks for its drivers to be turned off. After each of these conditions clears, the reset is held for a further minimum time before it is released.

The host reset input is asynchronous. It first passes through a synchronizer. A low level on it counts only after it has lasted longer than a qualification window. That window is given in picoseconds and converted to a whole number of clock cycles. Each qualified low level starts a reset of at least `MIN_CYC` cycles. If the host still holds its input low when that time ends, the reset continues until the host releases it. A new qualified low level that arrives while the minimum time is still running starts the minimum time again.

With the default parameters, the qualification window is `QUAL_CYC = QUAL_PS/CLK_PS + 1` = 5 samples, and the synchronizer has two stages.

Top module: `card_reset_gen`

## Requirements
- R1: While `rst_n` is low, `card_rst` is 1 and `card_rst_n` is 0.
- R2: `card_rst_n` is the inverse of `card_rst` on every cycle.
- R3: A host low level qualifies only after `QUAL_CYC` consecutive synchronized low samples.
  - Counting the edge after which `host_rst_n` fell as edge 0, `card_rst` rises on edge `SYNC_STAGES+QUAL_CYC+1`.
  - A low level shorter than `QUAL_CYC` cycles leaves both outputs unchanged.
- R4: A single synchronized high sample restarts the qualification count. Two short low levels separated by one high cycle therefore do not qualify, even if their total length is at least `QUAL_CYC`.
- R5: When the host input is already high again, a qualified reset stays asserted for exactly `MIN_CYC` cycles. It falls on the `MIN_CYC`-th edge after the edge on which it rose.
- R6: If the host input is still low when the minimum time ends, reset stays asserted. It falls on edge `SYNC_STAGES+2`, counting the edge after which the host input rose as edge 0.
- R7: A new qualification while the minimum time is running restarts it. Reset then falls `MIN_CYC` edges after the second rise point.
- R8: Any `mon_ok` bit at 0 asserts `card_rst` on the next edge. Reset falls `MIN_CYC` edges after the first edge that samples all bits at 1.
- R9: `pwr_en` at 0 behaves exactly as in R8.
- R10: `drv_off` at 1 behaves exactly as in R8.
- R11: After `rst_n` is released with all power inputs good, `card_rst` stays 1 on edges 1 to `MIN_CYC` and falls on edge `MIN_CYC+1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| host_rst_n | input | 1 | Asynchronous active-low host reset request |
| mon_ok | input | NUM_MON | Supply monitor flags, 1 = rail above its trip level |
| pwr_en | input | 1 | Power enable from the host, 0 forces reset |
| drv_off | input | 1 | Driver-disable request from the power controller, 1 forces reset |
| card_rst_n | output | 1 | Card reset, active low |
| card_rst | output | 1 | Card reset, active high |

## Verification
The latency of each result is counted in register stages:
- **Power inputs:** one stage, so a power change lands on the next edge.
- **Host input:** the synchronizer, the qualification counter and the output flop, so a host edge lands `SYNC_STAGES+QUAL_CYC+1` edges later. A host release lands `SYNC_STAGES+2` edges later.
- **Minimum time:** `MIN_CYC` edges after the rise or after the first good edge.

The bench works out these edge numbers from the cycle in which it changes a stimulus. It queues the expected level for every cycle of the window. A monitor compares each queued entry at the falling clock edge of exactly that cycle and reports any entry that it could not check in its cycle.

// File: rtl/crst_pkg.sv
`timescale 1ns/1ps
package crst_pkg;

    // Number of samples a low level must last to exceed the window
    function automatic int qual_samples(input int clk_ps, input int win_ps);
        return (win_ps / clk_ps) + 1;
    endfunction

    // Registered output pair, one flop per polarity
    typedef struct packed {
        logic act;
        logic act_n;
    } crst_out_t;

endpackage

// File: rtl/crst_sync.sv
`timescale 1ns/1ps
module crst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/crst_qual.sv
`timescale 1ns/1ps
module crst_qual #(
    parameter int QUAL_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low,
    output logic held,
    output logic hit
);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam logic [QW-1:0] FULL = QW'(QUAL_CYC);
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (low) begin
            if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = (st_q.cnt == FULL);
    assign hit  = low && (st_q.cnt == LAST);
endmodule

// File: rtl/crst_timer.sv
`timescale 1ns/1ps
module crst_timer #(
    parameter int MIN_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int TW = $clog2(MIN_CYC + 1);
    localparam logic [TW-1:0] FULL = TW'(MIN_CYC);

    typedef struct packed {
        logic [TW-1:0] left;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                 st_d.left = FULL;
        else if (st_q.left != '0) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.left <= FULL;
        else        st_q <= st_d;
    end

    assign busy = (st_q.left != '0);
endmodule

// File: rtl/card_reset_gen.sv
`timescale 1ns/1ps
module card_reset_gen
    import crst_pkg::*;
#(
    parameter int CLK_PS      = 10000,
    parameter int QUAL_PS     = 40000,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 1000,
    parameter int NUM_MON     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_rst_n,
    input  logic [NUM_MON-1:0] mon_ok,
    input  logic               pwr_en,
    input  logic               drv_off,
    output logic               card_rst_n,
    output logic               card_rst
);
    localparam int QUAL_CYC = qual_samples(CLK_PS, QUAL_PS);

    logic      host_s;
    logic      host_held;
    logic      host_hit;
    logic      power_bad;
    logic      tmr_busy;
    crst_out_t out_d, out_q;

    crst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (host_rst_n),
        .dout (host_s)
    );

    crst_qual #(.QUAL_CYC(QUAL_CYC)) i_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .low  (!host_s),
        .held (host_held),
        .hit  (host_hit)
    );

    assign power_bad = !pwr_en || drv_off || !(&mon_ok);

    crst_timer #(.MIN_CYC(MIN_CYC)) i_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (power_bad || host_hit),
        .busy (tmr_busy)
    );

    always_comb begin
        out_d       = out_q;
        out_d.act   = power_bad || host_held || tmr_busy;
        out_d.act_n = !(power_bad || host_held || tmr_busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.act   <= 1'b1;
            out_q.act_n <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign card_rst   = out_q.act;
    assign card_rst_n = out_q.act_n;
endmodule

// File: rtl/crst_chk.sv
`timescale 1ns/1ps
module crst_chk #(
    parameter int CLK_PS      = 10000,
    parameter int QUAL_PS     = 40000,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 1000,
    parameter int NUM_MON     = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_rst_n,
    input logic [NUM_MON-1:0] mon_ok,
    input logic               pwr_en,
    input logic               drv_off,
    input logic               card_rst_n,
    input logic               card_rst
);
    localparam int QUAL_CYC = (QUAL_PS / CLK_PS) + 1;
    localparam int HOLD_LAT = SYNC_STAGES + QUAL_CYC + 1;

    logic pwr_bad;
    int   run_q;
    int   low_q;

    assign pwr_bad = !pwr_en || drv_off || !(&mon_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
            low_q <= 0;
        end else begin
            run_q <= card_rst ? ((run_q < MIN_CYC + 1) ? run_q + 1 : run_q) : 0;
            low_q <= !host_rst_n ? ((low_q < HOLD_LAT) ? low_q + 1 : low_q) : 0;
        end
    end

    assert_rst_value_R1: assert property (@(posedge clk) !rst_n |=> (card_rst || !rst_n));

    assert_opposite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n != card_rst);

    assert_host_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q >= HOLD_LAT) |-> card_rst);

    assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_rst) |-> (run_q >= MIN_CYC));

    assert_power_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_bad |=> card_rst);

    assert_release_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_rst) |-> $past(!pwr_bad));
endmodule

bind card_reset_gen crst_chk #(
    .CLK_PS     (CLK_PS),
    .QUAL_PS    (QUAL_PS),
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_CYC    (MIN_CYC),
    .NUM_MON    (NUM_MON)
) i_crst_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rst_n(host_rst_n),
    .mon_ok    (mon_ok),
    .pwr_en    (pwr_en),
    .drv_off   (drv_off),
    .card_rst_n(card_rst_n),
    .card_rst  (card_rst)
);

// File: tb/test_card_reset_gen.sv
`timescale 1ns/1ps
module test_card_reset_gen;
    localparam int CLK_NS = 10;
    localparam int SYNC   = 2;
    localparam int MINC   = 20;
    localparam int NMON   = 3;
    localparam int Q      = 40 / CLK_NS + 1;
    localparam int RISE   = SYNC + Q + 1;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_rst_n = 1'b1;
    logic [NMON-1:0] mon_ok = '1;
    logic            pwr_en = 1'b1;
    logic            drv_off = 1'b0;
    logic            card_rst_n;
    logic            card_rst;

    exp_t sb[$];
    exp_t e;
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;

    card_reset_gen #(
        .CLK_PS(CLK_NS * 1000), .QUAL_PS(40000), .SYNC_STAGES(SYNC),
        .MIN_CYC(MINC), .NUM_MON(NMON)
    ) i_card_reset_gen (
        .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n), .mon_ok(mon_ok),
        .pwr_en(pwr_en), .drv_off(drv_off), .card_rst_n(card_rst_n), .card_rst(card_rst)
    );

    always #(CLK_NS / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor: compares each queued entry in its own cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc < cyc) begin
            e = sb.pop_front();
            n_cmp++; n_bad++;
            $display("FAIL %s: entry for cycle %0d not checked (now %0d), expected %0b",
                     e.tag, e.cyc, cyc, e.val);
        end
        if (sb.size() > 0 && sb[0].cyc == cyc) begin
            e = sb.pop_front();
            n_cmp++;
            if (card_rst !== e.val || card_rst_n !== ~e.val) begin
                n_bad++;
                $display("FAIL %s/R2: cycle %0d card_rst=%0b card_rst_n=%0b expected %0b/%0b",
                         e.tag, cyc, card_rst, card_rst_n, e.val, ~e.val);
            end
        end
    end

    task automatic push_span(input int lo, input int hi, input logic v, input string tag);
        for (int c = lo; c <= hi; c++) sb.push_back('{c, v, tag});
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic power_case(input int which, input int k, input string tag);
        int c0;
        c0 = cyc;
        push_span(c0 + 1, c0 + k + MINC, 1'b1, tag);
        push_span(c0 + k + MINC + 1, c0 + k + MINC + 4, 1'b0, tag);
        if (which == 0)      mon_ok[1] = 1'b0;
        else if (which == 1) pwr_en = 1'b0;
        else                 drv_off = 1'b1;
        repeat (k) @(negedge clk);
        mon_ok = '1; pwr_en = 1'b1; drv_off = 1'b0;
        wait_cyc(c0 + k + MINC + 6);
    endtask

    initial begin
        #(CLK_NS * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int c0, c1, r1, r2;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (card_rst !== 1'b1 || card_rst_n !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: card_rst=%0b card_rst_n=%0b expected 1/0", card_rst, card_rst_n);
        end
        rst_n = 1'b1;
        // R11: power-on release
        push_span(1, MINC, 1'b1, "R11");
        push_span(MINC + 1, MINC + 4, 1'b0, "R11");
        wait_cyc(MINC + 6);

        // R3: too short, ignored
        c0 = cyc;
        push_span(c0 + 1, c0 + RISE + 6, 1'b0, "R3");
        host_rst_n = 1'b0;
        repeat (Q - 1) @(negedge clk);
        host_rst_n = 1'b1;
        wait_cyc(c0 + RISE + 8);

        // R3 + R5: just long enough, minimum width
        c0 = cyc;
        r1 = c0 + RISE;
        push_span(c0 + 1, r1 - 1, 1'b0, "R3");
        push_span(r1, r1 + MINC - 1, 1'b1, "R5");
        push_span(r1 + MINC, r1 + MINC + 3, 1'b0, "R5");
        host_rst_n = 1'b0;
        repeat (Q) @(negedge clk);
        host_rst_n = 1'b1;
        wait_cyc(r1 + MINC + 5);

        // R6: host holds beyond the minimum
        c0 = cyc;
        r1 = c0 + RISE;
        r2 = c0 + (MINC + 15) + SYNC + 2;
        push_span(c0 + 1, r1 - 1, 1'b0, "R6");
        push_span(r1, r2 - 1, 1'b1, "R6");
        push_span(r2, r2 + 3, 1'b0, "R6");
        host_rst_n = 1'b0;
        repeat (MINC + 15) @(negedge clk);
        host_rst_n = 1'b1;
        wait_cyc(r2 + 5);

        // R7: retrigger restarts the minimum
        c0 = cyc;
        r1 = c0 + RISE;
        c1 = r1 + 4;
        r2 = c1 + RISE;
        push_span(c0 + 1, r1 - 1, 1'b0, "R7");
        push_span(r1, r2 + MINC - 1, 1'b1, "R7");
        push_span(r2 + MINC, r2 + MINC + 3, 1'b0, "R7");
        host_rst_n = 1'b0;
        repeat (Q) @(negedge clk);
        host_rst_n = 1'b1;
        wait_cyc(c1);
        host_rst_n = 1'b0;
        repeat (Q) @(negedge clk);
        host_rst_n = 1'b1;
        wait_cyc(r2 + MINC + 5);

        // R4: broken low level does not qualify
        c0 = cyc;
        push_span(c0 + 1, c0 + 20, 1'b0, "R4");
        host_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        host_rst_n = 1'b1;
        @(negedge clk);
        host_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        host_rst_n = 1'b1;
        wait_cyc(c0 + 22);

        // R8, R9, R10: power conditions
        power_case(0, 4, "R8");
        power_case(1, 1, "R9");
        power_case(2, 7, "R10");

        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL end: %0d entries left, expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule